// File: doc/BRIEF.md
# Memory Card Byte-Lane Decoder

This block sits on the card side of a 68-pin memory card interface. It watches the host strobes (space select, the two card enables, output enable, write enable), the write-protect switch and the byte address, and from them produces the chip selects for two banks of byte-wide SRAM devices, one holding even bytes and one holding odd bytes. It also produces the select and write strobe for a byte-wide attribute store, and the steering controls for the data-bus buffer between the host lanes and the two banks.

The two card enables and address bit 0 together decide the transfer width and which lane each byte travels on. In 8-bit mode with only the low enable active, both even and odd bytes travel on the low lane and address bit 0 picks between them. With only the high enable active, the odd byte travels on the high lane. With both enables active, a full 16-bit word moves. Attribute space holds even bytes only. The write-protect switch suppresses every write in both spaces. All outputs are registered, so each decode is presented one clock after the strobes are sampled.

Top module: `card_lane_decoder`

## Requirements
- R1: While `rst` is high at a clock edge, every chip select and write strobe goes to its inactive level (1), and both buffer lane enables and both steering controls go to 0.
- R2: Every output reflects the inputs sampled at the previous rising clock edge. A change in the strobes does not reach the outputs before that edge.
- R3: With `host_ce_lo_n`=0 and `host_ce_hi_n`=1 in common space, `host_addr[0]`=0 selects the even bank and `host_addr[0]`=1 selects the odd bank. A read enables only the low lane (`buf_lo_oe`=1, `buf_hi_oe`=0). `buf_lo_from_odd`=1 marks that the low lane carries the odd bank.
- R4: With `host_ce_lo_n`=1 and `host_ce_hi_n`=0, only the odd bank is selected, a read enables only the high lane, and `host_addr[0]` has no effect on any output.
- R5: With both card enables at 0, both banks are selected, a read enables both lanes, and `host_addr[0]` has no effect.
- R6: With both card enables at 1 (standby), or with `host_oe_n` and `host_we_n` both 1, no chip select, no write strobe and no lane enable is asserted.
- R7: A lane enable is asserted only for a cycle whose inputs had `host_oe_n`=0, `host_we_n`=1 and at least one card enable at 0. With both `host_oe_n` and `host_we_n` at 0, the cycle is a write and both lanes stay disabled.
- R8: With `host_space_n`=0 (attribute space), the bank chip selects and `mem_oe_n`/`mem_we_n` stay inactive. `attr_cs_n` goes low only when the even byte is addressed. A read still enables the lanes given by R3 to R5, and `buf_lo_from_odd` stays 0.
- R9: An attribute write asserts `attr_we_n`=0 only when the even byte is part of the access. An 8-bit odd write and a write with only the high enable active leave `attr_cs_n` and `attr_we_n` at 1.
- R10: With `wp_on`=1, every write in either space is suppressed: no chip select and no write strobe is asserted. Reads behave exactly as with `wp_on`=0.
- R11: The device field `host_addr[DEV_AW+1 +: log2(NUM_DEV)]` selects exactly one device in the enabled bank. `mem_addr` equals `host_addr[DEV_AW:1]` and `attr_addr` equals `host_addr[ATTR_AW:1]`.
- R12: Address bits above the populated range (`host_addr[ADDR_W-1:DEV_AW+1+log2(NUM_DEV)]`) have no effect on any output.
- R13: On an 8-bit odd-byte access through the low enable, `buf_odd_from_lo`=1, so the odd bank takes its write data from the low lane. Otherwise it is 0, and the odd bank writes from the high lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Decode clock |
| rst | input | 1 | Synchronous reset, active high |
| host_space_n | input | 1 | 0 selects attribute space, 1 selects common space |
| host_ce_lo_n | input | 1 | Low card enable, active low |
| host_ce_hi_n | input | 1 | High card enable, active low |
| host_oe_n | input | 1 | Host output enable, active low |
| host_we_n | input | 1 | Host write enable, active low |
| wp_on | input | 1 | Write-protect switch, 1 = protected |
| host_addr | input | ADDR_W | Host byte address |
| even_cs_n | output | NUM_DEV | Even-bank device selects, active low |
| odd_cs_n | output | NUM_DEV | Odd-bank device selects, active low |
| mem_addr | output | DEV_AW | Word address inside a device |
| mem_oe_n | output | 1 | Bank output enable, active low |
| mem_we_n | output | 1 | Bank write enable, active low |
| attr_cs_n | output | 1 | Attribute store select, active low |
| attr_we_n | output | 1 | Attribute store write enable, active low |
| attr_addr | output | ATTR_AW | Attribute store even-byte address |
| buf_lo_oe | output | 1 | Drive host low lane toward the host |
| buf_hi_oe | output | 1 | Drive host high lane toward the host |
| buf_lo_from_odd | output | 1 | Low lane carries the odd bank (else even bank) |
| buf_odd_from_lo | output | 1 | Odd bank writes from low lane (else high lane) |

## Verification
Every result of this block is due exactly one rising edge after the strobes are applied. The bench drives inputs on a falling edge and samples on the next falling edge, half a period after the register that carries the result. One directed test looks 2 ns after driving, before that rising edge, to show the old decode is still present. The byte-lane steering is also checked end to end: small even and odd byte arrays in the bench are written and read through the select, write and steering outputs, so a wrong lane choice shows up as wrong data on the host side.

// File: rtl/card_lane_pkg.sv
package card_lane_pkg;

    // Transfer width selected by the two card enables: {high active, low active}
    typedef enum logic [1:0] {
        LM_IDLE = 2'b00,
        LM_LO8  = 2'b01,
        LM_HI8  = 2'b10,
        LM_W16  = 2'b11
    } lane_mode_e;

    // Per-access lane decision
    typedef struct packed {
        logic even_sel;
        logic odd_sel;
        logic lo_oe;
        logic hi_oe;
        logic lo_from_odd;
        logic odd_from_lo;
    } lane_ctl_t;

    function automatic lane_mode_e mode_of(input logic ce_lo_n, input logic ce_hi_n);
        return lane_mode_e'({~ce_hi_n, ~ce_lo_n});
    endfunction

    function automatic logic is_read(input lane_mode_e m, input logic oe_n, input logic we_n);
        return (m != LM_IDLE) && !oe_n && we_n;
    endfunction

    function automatic logic is_write(input lane_mode_e m, input logic we_n);
        return (m != LM_IDLE) && !we_n;
    endfunction

endpackage

// File: rtl/card_lane_steer.sv
module card_lane_steer
    import card_lane_pkg::*;
(
    input  lane_mode_e mode,
    input  logic       a0,
    input  logic       common,
    input  logic       rd,
    input  logic       wr,
    input  logic       wp,
    output lane_ctl_t  ctl,
    output logic       wr_ok
);

    always_comb begin
        ctl = '0;
        unique case (mode)
            LM_LO8: begin
                ctl.even_sel    = !a0;
                ctl.odd_sel     = a0;
                ctl.lo_oe       = rd;
                ctl.lo_from_odd = a0 && common;
                ctl.odd_from_lo = a0;
            end
            LM_HI8: begin
                ctl.odd_sel = 1'b1;
                ctl.hi_oe   = rd;
            end
            LM_W16: begin
                ctl.even_sel = 1'b1;
                ctl.odd_sel  = 1'b1;
                ctl.lo_oe    = rd;
                ctl.hi_oe    = rd;
            end
            default: ctl = '0;
        endcase
    end

    assign wr_ok = wr && !wp;

endmodule

// File: rtl/card_bank_sel.sv
module card_bank_sel #(
    parameter int ADDR_W  = 23,
    parameter int DEV_AW  = 18,
    parameter int NUM_DEV = 4
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic               en_even,
    input  logic               en_odd,
    output logic [NUM_DEV-1:0] even_n,
    output logic [NUM_DEV-1:0] odd_n
);

    localparam int SEL_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
    localparam int SEL_LSB = DEV_AW + 1;

    logic [SEL_W-1:0] dev_idx;

    // Masking with the device count drops every bit above the populated range
    assign dev_idx = SEL_W'((addr >> SEL_LSB) & ADDR_W'(NUM_DEV - 1));

    for (genvar i = 0; i < NUM_DEV; i++) begin : g_dev
        assign even_n[i] = !(en_even && (dev_idx == SEL_W'(i)));
        assign odd_n[i]  = !(en_odd  && (dev_idx == SEL_W'(i)));
    end

endmodule

// File: rtl/card_lane_decoder.sv
module card_lane_decoder
    import card_lane_pkg::*;
#(
    parameter int ADDR_W  = 23,
    parameter int DEV_AW  = 18,
    parameter int NUM_DEV = 4,
    parameter int ATTR_AW = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_space_n,
    input  logic               host_ce_lo_n,
    input  logic               host_ce_hi_n,
    input  logic               host_oe_n,
    input  logic               host_we_n,
    input  logic               wp_on,
    input  logic [ADDR_W-1:0]  host_addr,
    output logic [NUM_DEV-1:0] even_cs_n,
    output logic [NUM_DEV-1:0] odd_cs_n,
    output logic [DEV_AW-1:0]  mem_addr,
    output logic               mem_oe_n,
    output logic               mem_we_n,
    output logic               attr_cs_n,
    output logic               attr_we_n,
    output logic [ATTR_AW-1:0] attr_addr,
    output logic               buf_lo_oe,
    output logic               buf_hi_oe,
    output logic               buf_lo_from_odd,
    output logic               buf_odd_from_lo
);

    lane_mode_e mode;
    lane_ctl_t  ctl;
    logic       rd, wr, wr_ok, common, acc;
    logic [NUM_DEV-1:0] even_d, odd_d;

    assign mode   = mode_of(host_ce_lo_n, host_ce_hi_n);
    assign rd     = is_read(mode, host_oe_n, host_we_n);
    assign wr     = is_write(mode, host_we_n);
    assign common = host_space_n;

    card_lane_steer u_steer (
        .mode   (mode),
        .a0     (host_addr[0]),
        .common (common),
        .rd     (rd),
        .wr     (wr),
        .wp     (wp_on),
        .ctl    (ctl),
        .wr_ok  (wr_ok)
    );

    assign acc = rd || wr_ok;

    card_bank_sel #(
        .ADDR_W  (ADDR_W),
        .DEV_AW  (DEV_AW),
        .NUM_DEV (NUM_DEV)
    ) u_bank (
        .addr    (host_addr),
        .en_even (common && acc && ctl.even_sel),
        .en_odd  (common && acc && ctl.odd_sel),
        .even_n  (even_d),
        .odd_n   (odd_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            even_cs_n       <= '1;
            odd_cs_n        <= '1;
            mem_addr        <= '0;
            mem_oe_n        <= 1'b1;
            mem_we_n        <= 1'b1;
            attr_cs_n       <= 1'b1;
            attr_we_n       <= 1'b1;
            attr_addr       <= '0;
            buf_lo_oe       <= 1'b0;
            buf_hi_oe       <= 1'b0;
            buf_lo_from_odd <= 1'b0;
            buf_odd_from_lo <= 1'b0;
        end else begin
            even_cs_n       <= even_d;
            odd_cs_n        <= odd_d;
            mem_addr        <= host_addr[DEV_AW:1];
            mem_oe_n        <= !(common && rd);
            mem_we_n        <= !(common && wr_ok);
            attr_cs_n       <= !(!common && acc && ctl.even_sel);
            attr_we_n       <= !(!common && wr_ok && ctl.even_sel);
            attr_addr       <= host_addr[ATTR_AW:1];
            buf_lo_oe       <= ctl.lo_oe;
            buf_hi_oe       <= ctl.hi_oe;
            buf_lo_from_odd <= ctl.lo_from_odd;
            buf_odd_from_lo <= ctl.odd_from_lo;
        end
    end

    // R6: standby leaves everything quiet one cycle later
    a_r6_standby_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(host_ce_lo_n && host_ce_hi_n) |->
            (&even_cs_n) && (&odd_cs_n) && attr_cs_n && !buf_lo_oe && !buf_hi_oe);

    // R7: a lane drives toward the host only after a genuine read strobe
    a_r7_lane_needs_read: assert property (@(posedge clk) disable iff (rst)
        (buf_lo_oe || buf_hi_oe) |->
            $past(!host_oe_n && host_we_n && !(host_ce_lo_n && host_ce_hi_n)));

    // R8: attribute and common selects never coexist
    a_r8_space_exclusive: assert property (@(posedge clk) disable iff (rst)
        !attr_cs_n |-> (&even_cs_n) && (&odd_cs_n) && mem_oe_n && mem_we_n);

    // R9: attribute write strobe only when the even byte was addressed
    a_r9_attr_even_only: assert property (@(posedge clk) disable iff (rst)
        !attr_we_n |-> $past(!host_ce_lo_n && (!host_ce_hi_n || !host_addr[0])));

    // R10: protection blocks every write strobe
    a_r10_wp_blocks_write: assert property (@(posedge clk) disable iff (rst)
        $past(wp_on) |-> mem_we_n && attr_we_n);

    // R11: at most one device per bank
    a_r11_one_device: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~even_cs_n) && $onehot0(~odd_cs_n));

endmodule

// File: tb/card_lane_decoder_bench.sv
module card_lane_decoder_bench;
    localparam int ADDR_W  = 23;
    localparam int DEV_AW  = 18;
    localparam int NUM_DEV = 4;
    localparam int ATTR_AW = 12;
    localparam int SEL_LSB = DEV_AW + 1;
    localparam int NVEC    = 21;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic space_n = 1'b1, ce_lo_n = 1'b1, ce_hi_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, wp = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [15:0] wd = '0;

    logic [NUM_DEV-1:0] even_cs_n, odd_cs_n;
    logic [DEV_AW-1:0]  mem_addr;
    logic [ATTR_AW-1:0] attr_addr;
    logic mem_oe_n, mem_we_n, attr_cs_n, attr_we_n;
    logic buf_lo_oe, buf_hi_oe, buf_lo_from_odd, buf_odd_from_lo;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] even_mem [0:63];
    logic [7:0] odd_mem  [0:63];

    always #4 clk = ~clk;

    card_lane_decoder #(
        .ADDR_W(ADDR_W), .DEV_AW(DEV_AW), .NUM_DEV(NUM_DEV), .ATTR_AW(ATTR_AW)
    ) u_card_lane_decoder (
        .clk(clk), .rst(rst),
        .host_space_n(space_n), .host_ce_lo_n(ce_lo_n), .host_ce_hi_n(ce_hi_n),
        .host_oe_n(oe_n), .host_we_n(we_n), .wp_on(wp), .host_addr(addr),
        .even_cs_n(even_cs_n), .odd_cs_n(odd_cs_n), .mem_addr(mem_addr),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .attr_cs_n(attr_cs_n), .attr_we_n(attr_we_n), .attr_addr(attr_addr),
        .buf_lo_oe(buf_lo_oe), .buf_hi_oe(buf_hi_oe),
        .buf_lo_from_odd(buf_lo_from_odd), .buf_odd_from_lo(buf_odd_from_lo)
    );

    // {req, inputs {space_n,ce_lo_n,ce_hi_n,oe_n,we_n,wp,a0},
    //  expected {even,odd,mem_oe_n,mem_we_n,attr_cs_n,attr_we_n,lo_oe,hi_oe,lo_from_odd,odd_from_lo}}
    localparam logic [20:0] VEC [0:NVEC-1] = '{
        {4'd3,  7'b1010100, 10'b1001111000},  // R3 even byte read, low lane
        {4'd3,  7'b1010101, 10'b0101111011},  // R3 odd byte read, low lane
        {4'd4,  7'b1100100, 10'b0101110100},  // R4 high enable read
        {4'd4,  7'b1100101, 10'b0101110100},  // R4 A0 ignored
        {4'd5,  7'b1000101, 10'b1101111100},  // R5 word read, A0 ignored
        {4'd6,  7'b1110100, 10'b0011110000},  // R6 standby
        {4'd6,  7'b1001100, 10'b0011110000},  // R6 outputs disabled
        {4'd3,  7'b1011000, 10'b1010110000},  // R3 even byte write
        {4'd13, 7'b1011001, 10'b0110110011},  // R13 odd byte write from low lane
        {4'd5,  7'b1001000, 10'b1110110000},  // R5 word write
        {4'd10, 7'b1001010, 10'b0011110000},  // R10 protected word write
        {4'd10, 7'b1010111, 10'b0101111011},  // R10 protected read unaffected
        {4'd8,  7'b0010100, 10'b0011011000},  // R8 attribute even read
        {4'd8,  7'b0010101, 10'b0011111001},  // R8 attribute odd read
        {4'd8,  7'b0000100, 10'b0011011100},  // R8 attribute word read
        {4'd9,  7'b0011000, 10'b0011000000},  // R9 attribute even write
        {4'd9,  7'b0011001, 10'b0011110001},  // R9 attribute odd write ignored
        {4'd9,  7'b0101000, 10'b0011110000},  // R9 attribute high-only write ignored
        {4'd9,  7'b0001000, 10'b0011000000},  // R9 attribute word write
        {4'd10, 7'b0011010, 10'b0011110000},  // R10 protected attribute write
        {4'd7,  7'b1000000, 10'b1110110000}   // R7 OE and WE both low: write, lanes off
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic s, input logic l, input logic h, input logic o,
                         input logic w, input logic p, input logic [ADDR_W-1:0] a);
        space_n = s; ce_lo_n = l; ce_hi_n = h; oe_n = o; we_n = w; wp = p; addr = a;
    endtask

    // Apply at a falling edge, sample at the following falling edge; update the bank model
    task automatic cycle(input logic s, input logic l, input logic h, input logic o,
                         input logic w, input logic p, input logic [ADDR_W-1:0] a,
                         input logic [15:0] data);
        @(negedge clk);
        drive(s, l, h, o, w, p, a);
        wd = data;
        @(negedge clk);
        if (!mem_we_n) begin
            for (int d = 0; d < NUM_DEV; d++) begin
                if (!even_cs_n[d]) even_mem[{d[1:0], mem_addr[3:0]}] = wd[7:0];
                if (!odd_cs_n[d])
                    odd_mem[{d[1:0], mem_addr[3:0]}] = buf_odd_from_lo ? wd[7:0] : wd[15:8];
            end
        end
    endtask

    function automatic logic [15:0] host_bus();
        logic [7:0] lo, hi, ev, od;
        ev = 8'h00; od = 8'h00;
        for (int d = 0; d < NUM_DEV; d++) begin
            if (!even_cs_n[d]) ev = even_mem[{d[1:0], mem_addr[3:0]}];
            if (!odd_cs_n[d])  od = odd_mem[{d[1:0], mem_addr[3:0]}];
        end
        lo = buf_lo_oe ? (buf_lo_from_odd ? od : ev) : 8'h00;
        hi = buf_hi_oe ? od : 8'h00;
        return {hi, lo};
    endfunction

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [ADDR_W-1:0] base, wa;
        logic [NUM_DEV-1:0] e_exp, o_exp;
        logic [9:0] got, exp;
        for (int i = 0; i < 64; i++) begin
            even_mem[i] = 8'h00;
            odd_mem[i]  = 8'h00;
        end

        // R1: reset overrides an active word read
        drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, '0);
        repeat (3) @(negedge clk);
        check((&even_cs_n) && (&odd_cs_n) && mem_oe_n && mem_we_n && attr_cs_n && attr_we_n
              && !buf_lo_oe && !buf_hi_oe && !buf_lo_from_odd && !buf_odd_from_lo,
              "R1", {even_cs_n, odd_cs_n, buf_lo_oe, buf_hi_oe}, {4'hF, 4'hF, 2'b00});
        drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, '0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // Vector table, device 2
        base = ADDR_W'(2) << SEL_LSB | ADDR_W'(6 << 1);
        for (int v = 0; v < NVEC; v++) begin
            cycle(VEC[v][16], VEC[v][15], VEC[v][14], VEC[v][13], VEC[v][12], VEC[v][11],
                  base | ADDR_W'(VEC[v][10]), 16'h0000);
            exp   = VEC[v][9:0];
            e_exp = exp[9] ? ~(NUM_DEV'(1) << 2) : '1;
            o_exp = exp[8] ? ~(NUM_DEV'(1) << 2) : '1;
            got   = {!(&even_cs_n), !(&odd_cs_n), mem_oe_n, mem_we_n, attr_cs_n, attr_we_n,
                     buf_lo_oe, buf_hi_oe, buf_lo_from_odd, buf_odd_from_lo};
            n_run++;
            if (got != exp || even_cs_n != e_exp || odd_cs_n != o_exp) begin
                n_fail++;
                $display("FAIL R%0d vector %0d: actual %b/%b/%b expected %b/%b/%b",
                         VEC[v][20:17], v, got, even_cs_n, odd_cs_n, exp, e_exp, o_exp);
            end
        end

        // R2: decode appears only after the next rising edge
        cycle(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, '0, 16'h0);
        @(negedge clk);
        drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, '0);
        #2;
        check((&even_cs_n) && !buf_lo_oe, "R2", {even_cs_n, buf_lo_oe}, {4'hF, 1'b0});
        @(negedge clk);
        check(even_cs_n == 4'b1110 && buf_lo_oe && buf_hi_oe, "R2",
              {even_cs_n, buf_lo_oe, buf_hi_oe}, {4'b1110, 2'b11});

        // R11: device field, in-device address and attribute address
        for (int d = 0; d < NUM_DEV; d++) begin
            wa = (ADDR_W'(d) << SEL_LSB) | ADDR_W'(18'h2A5B5 << 1);
            cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, wa, 16'h0);
            check(even_cs_n == ~(NUM_DEV'(1) << d) && odd_cs_n == ~(NUM_DEV'(1) << d),
                  "R11", {even_cs_n, odd_cs_n}, {~(NUM_DEV'(1) << d), ~(NUM_DEV'(1) << d)});
            check(mem_addr == 18'h2A5B5, "R11", 32'(mem_addr), 32'h2A5B5);
        end
        cycle(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, ADDR_W'(13'h1ABC), 16'h0);
        check(attr_addr == 12'hD5E && !attr_cs_n, "R11", 32'(attr_addr), 32'hD5E);

        // R12: bits above the populated range do not change selects or address
        wa = (ADDR_W'(1) << SEL_LSB) | ADDR_W'(5 << 1) | (ADDR_W'(3) << (SEL_LSB + 2));
        cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, wa, 16'h0);
        check(even_cs_n == 4'b1101 && odd_cs_n == 4'b1101 && mem_addr == 18'd5, "R12",
              {even_cs_n, odd_cs_n, mem_addr[3:0]}, {4'b1101, 4'b1101, 4'd5});

        // Data through the steering controls, device 1 word 5
        wa = (ADDR_W'(1) << SEL_LSB) | ADDR_W'(5 << 1);
        cycle(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, wa, 16'hA55A);          // R5 word write
        cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, wa, 16'h0);
        check(host_bus() == 16'hA55A, "R5", 32'(host_bus()), 32'hA55A);
        cycle(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, wa | 1, 16'h003C);      // R13 odd via low lane
        cycle(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, wa | 1, 16'h0);
        check(host_bus() == 16'h003C, "R13", 32'(host_bus()), 32'h003C);
        cycle(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, wa, 16'h0);
        check(host_bus() == 16'h005A, "R3", 32'(host_bus()), 32'h005A);
        cycle(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, wa | 1, 16'h7700);      // R4 odd via high lane
        cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, wa, 16'h0);
        check(host_bus() == 16'h775A, "R4", 32'(host_bus()), 32'h775A);
        cycle(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, wa, 16'hFFFF);          // R10 protected write
        cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, wa | (ADDR_W'(1) << 22), 16'h0);
        check(host_bus() == 16'h775A, "R10", 32'(host_bus()), 32'h775A);
        cycle(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, wa, 16'h0);
        check(host_bus() == 16'h7700, "R4", 32'(host_bus()), 32'h7700);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule